// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that takes its work from a chain of descriptors held in memory instead of from directly programmed address and length registers. Software writes the byte address of the first descriptor into the channel's register window and sets the run bit. The channel reads six words over a word-wide memory port: config, source, destination, byte count, parameter and link. It decodes the config word, moves the byte count from source to destination one beat at a time, and then follows the link word. A link equal to the chain terminator stops the channel and clears the run bit.

Every beat is a word read followed by a word write with byte strobes. The beat size is the smaller of the source and destination element sizes, capped at one word, so a 64-bit setting runs as two word beats. Each side either advances its address by the beat size or stays on one fixed address, which suits an I/O port. Beats are grouped into bursts, and a programmable number of idle cycles separates one burst from the next. A pause bit stalls the channel between beats. Read-only status words show the live config, addresses, remaining bytes and parameter word. A single-cycle pulse marks the end of each descriptor.

Top module: `ldma_chan`

## Requirements
- R1: After reset every register word reads 0, `mem_req` is low and `done_o` is low. While the channel is idle it issues no memory request.
- R2: Writing 1 to bit 0 of word 0x00 while the channel is stopped starts it. The channel first reads the six descriptor words from the start address plus 0, 4, 8, 12, 16 and 20, in that order. Afterwards word 0x0C reads back the descriptor's config word and word 0x1C reads back its parameter word.
- R3: Element size codes sit in config bits 26:25 (destination) and 10:9 (source), where 0/1/2/3 mean 1/2/4/8 bytes. The beat size B is min(source size, destination size, 4). Each beat reads the word holding the source address and writes B bytes at the destination address's byte lanes. Exactly B write strobes are set, and bytes outside them are left untouched.
- R4: Config bit 21 (destination) and bit 5 (source) select the addressing mode. Mode 0 adds B to the address after each beat. Mode 1 keeps the address fixed. Words 0x10 and 0x14 show the current source and destination addresses.
- R5: Word 0x18 shows the bytes left and drops by B on every write. When it reaches zero, `done_o` is high for exactly one cycle. A descriptor with a byte count of zero produces the pulse with no data access.
- R6: When the link word equals END_MARK (0xFFFFF800), the channel stops and bit 0 of word 0x00 reads 0. Any other link value is the byte address of the next descriptor, which the channel then fetches and runs.
- R7: Config bits 23:22 give the burst length: 0/1/2/3 mean 1/4/8/16 beats. After each complete burst that leaves bytes to move, `mem_req` stays low for exactly the number of cycles in parameter bits 7:0.
- R8: While bit 0 of word 0x04 is set, the channel stops before the next data beat. It issues no request and the bytes-left value stays the same. Clearing the bit resumes the transfer, and the data that results is correct.
- R9: Writing 0 to bit 0 of word 0x00 halts the channel. `mem_req` is low from the next cycle on, no further write happens, and no completion pulse follows.
- R10: While `mem_ack` is low, a pending request keeps `mem_req`, `mem_addr` and `mem_we` unchanged, and the transfer still completes correctly.
- R11: Word 0x08 stores the start address with bits 1:0 forced to zero. Writes to the read-only words 0x0C to 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Byte offset inside the channel window; bits 5:2 pick the word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, lane-aligned to the destination |
| mem_be | output | 4 | Byte write strobes |
| mem_ack | input | 1 | Access accepted; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| done_o | output | 1 | One-cycle pulse when a descriptor finishes |

## Verification
The bench steers beats onto unaligned byte and halfword lanes, with source and destination on different lanes, and compares every destination byte against a byte-level model. A wrong lane rotation or strobe mask shows up as shifted or clobbered bytes. Fixed-address runs check that the address registers stay put; a design that still advanced them would scatter data and report wrong final addresses.

Separate runs measure the idle gaps between bursts, both with one-beat bursts and with four-beat bursts, where an off-by-one gap counter would show up as a gap one cycle too short or too long. A two-descriptor chain and a zero-length descriptor check that the link is followed and that the pulse is counted correctly. Pause, halt and a stalling memory target check that the channel neither leaks a beat while paused or halted nor loses one while stalled.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;

   // word index (cfg_addr[5:2]) of each register in the channel window
   localparam logic [3:0] W_RUN   = 4'd0;
   localparam logic [3:0] W_PAUSE = 4'd1;
   localparam logic [3:0] W_START = 4'd2;
   localparam logic [3:0] W_CFG   = 4'd3;
   localparam logic [3:0] W_SRC   = 4'd4;
   localparam logic [3:0] W_DST   = 4'd5;
   localparam logic [3:0] W_LEFT  = 4'd6;
   localparam logic [3:0] W_PARAM = 4'd7;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_RD, ST_WR, ST_GAP, ST_HOLD, ST_NEXT
   } ldma_state_e;

   // beat size code: min of both element size codes, capped at one word
   function automatic logic [1:0] beat_code(input logic [1:0] a, input logic [1:0] b);
      logic [1:0] m;
      m = (a < b) ? a : b;
      return (m > 2'd2) ? 2'd2 : m;
   endfunction

   // index of the final beat inside one burst
   function automatic logic [3:0] burst_last(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd3;
         2'd2:    return 4'd7;
         default: return 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/ldma_regs.sv
module ldma_regs
   import ldma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   input  logic              fin_i,
   input  logic [WORD_W-1:0] st_cfg_i,
   input  logic [WORD_W-1:0] st_src_i,
   input  logic [WORD_W-1:0] st_dst_i,
   input  logic [WORD_W-1:0] st_left_i,
   input  logic [WORD_W-1:0] st_param_i,
   output logic              run_o,
   output logic              pause_o,
   output logic              kick_o,
   output logic [WORD_W-1:0] start_o
);

   logic [3:0] widx;
   logic       run_q, pause_q;
   logic [WORD_W-1:0] start_q;

   assign widx = cfg_addr[5:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pause_q <= 1'b0;
         start_q <= '0;
      end else begin
         if (cfg_we && widx == W_RUN)        run_q <= cfg_wdata[0];
         else if (fin_i)                     run_q <= 1'b0;
         if (cfg_we && widx == W_PAUSE)      pause_q <= cfg_wdata[0];
         if (cfg_we && widx == W_START)      start_q <= {cfg_wdata[WORD_W-1:2], 2'b00};
      end
   end

   assign kick_o  = cfg_we && (widx == W_RUN) && cfg_wdata[0] && !run_q;
   assign run_o   = run_q;
   assign pause_o = pause_q;
   assign start_o = start_q;

   always_comb begin
      case (widx)
         W_RUN:   cfg_rdata = {{(WORD_W-1){1'b0}}, run_q};
         W_PAUSE: cfg_rdata = {{(WORD_W-1){1'b0}}, pause_q};
         W_START: cfg_rdata = start_q;
         W_CFG:   cfg_rdata = st_cfg_i;
         W_SRC:   cfg_rdata = st_src_i;
         W_DST:   cfg_rdata = st_dst_i;
         W_LEFT:  cfg_rdata = st_left_i;
         W_PARAM: cfg_rdata = st_param_i;
         default: cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ldma_lane.sv
module ldma_lane
   import ldma_pkg::*;
(
   input  logic [1:0]        src_code_i,
   input  logic [1:0]        dst_code_i,
   input  logic [1:0]        src_lane_i,
   input  logic [1:0]        dst_lane_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [WORD_W-1:0] wdata_o,
   output logic [LANES-1:0]  be_o,
   output logic [2:0]        beat_bytes_o
);

   logic [2:0] nbytes;

   assign nbytes       = 3'd1 << beat_code(src_code_i, dst_code_i);
   assign beat_bytes_o = nbytes;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [1:0] pick;
      logic [2:0] rel;
      always_comb begin
         pick = 2'(i) - dst_lane_i + src_lane_i;
         rel  = 3'(i) - {1'b0, dst_lane_i};
      end
      assign be_o[i]          = (2'(i) >= dst_lane_i) && (rel < nbytes);
      assign wdata_o[8*i +: 8] = data_i[8*pick +: 8];
   end

endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
   import ldma_pkg::*;
#(
   parameter logic [31:0] END_MARK = 32'hFFFF_F800,
   parameter int          WAIT_W   = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              pause_i,
   input  logic              kick_i,
   input  logic [WORD_W-1:0] start_i,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic [2:0]        beat_bytes_i,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] data_o,
   output logic [WORD_W-1:0] cfg_o,
   output logic [WORD_W-1:0] src_o,
   output logic [WORD_W-1:0] dst_o,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] param_o,
   output logic              done_o,
   output logic              fin_o,
   output ldma_state_e       state_o
);

   localparam int SRC_FIX_BIT = 5;
   localparam int DST_FIX_BIT = 21;
   localparam int BURST_LSB   = 22;

   ldma_state_e       state_q, beat_st;
   logic [2:0]        k_q;
   logic [3:0]        bcnt_q;
   logic [WAIT_W-1:0] gcnt_q, wait_v;
   logic [WORD_W-1:0] dptr_q, cfg_q, src_q, dst_q, left_q, param_q, next_q, data_q, left_n;

   assign wait_v  = param_q[WAIT_W-1:0];
   assign beat_st = pause_i ? ST_HOLD : ST_RD;
   assign left_n  = left_q - WORD_W'(beat_bytes_i);

   assign mem_req = run_i && (state_q == ST_FETCH || state_q == ST_RD || state_q == ST_WR);
   assign mem_we  = (state_q == ST_WR);
   always_comb begin
      case (state_q)
         ST_FETCH: mem_addr = dptr_q + {{(WORD_W-5){1'b0}}, k_q, 2'b00};
         ST_WR:    mem_addr = {dst_q[WORD_W-1:2], 2'b00};
         default:  mem_addr = {src_q[WORD_W-1:2], 2'b00};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         k_q     <= '0;
         bcnt_q  <= '0;
         gcnt_q  <= '0;
         dptr_q  <= '0;
         cfg_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         left_q  <= '0;
         param_q <= '0;
         next_q  <= '0;
         data_q  <= '0;
      end else if (state_q != ST_IDLE && !run_i) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (kick_i) begin
               dptr_q  <= start_i;
               k_q     <= '0;
               state_q <= ST_FETCH;
            end
            ST_FETCH: if (mem_ack) begin
               case (k_q)
                  3'd0:    cfg_q   <= mem_rdata;
                  3'd1:    src_q   <= mem_rdata;
                  3'd2:    dst_q   <= mem_rdata;
                  3'd3:    left_q  <= mem_rdata;
                  3'd4:    param_q <= mem_rdata;
                  default: next_q  <= mem_rdata;
               endcase
               k_q <= k_q + 3'd1;
               if (k_q == 3'd5) begin
                  bcnt_q  <= '0;
                  state_q <= (left_q == '0) ? ST_NEXT : beat_st;
               end
            end
            ST_RD: if (mem_ack) begin
               data_q  <= mem_rdata;
               state_q <= ST_WR;
            end
            ST_WR: if (mem_ack) begin
               left_q <= left_n;
               if (!cfg_q[SRC_FIX_BIT]) src_q <= src_q + WORD_W'(beat_bytes_i);
               if (!cfg_q[DST_FIX_BIT]) dst_q <= dst_q + WORD_W'(beat_bytes_i);
               if (left_n == '0) begin
                  state_q <= ST_NEXT;
               end else if (bcnt_q == burst_last(cfg_q[BURST_LSB +: 2])) begin
                  bcnt_q <= '0;
                  if (wait_v != '0) begin
                     gcnt_q  <= wait_v;
                     state_q <= ST_GAP;
                  end else begin
                     state_q <= beat_st;
                  end
               end else begin
                  bcnt_q  <= bcnt_q + 4'd1;
                  state_q <= beat_st;
               end
            end
            ST_GAP: begin
               if (gcnt_q == WAIT_W'(1)) state_q <= beat_st;
               else                      gcnt_q  <= gcnt_q - WAIT_W'(1);
            end
            ST_HOLD: if (!pause_i) state_q <= ST_RD;
            ST_NEXT: begin
               if (next_q == END_MARK) begin
                  state_q <= ST_IDLE;
               end else begin
                  dptr_q  <= next_q;
                  k_q     <= '0;
                  state_q <= ST_FETCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o  = (state_q == ST_NEXT);
   assign fin_o   = (state_q == ST_NEXT) && (next_q == END_MARK);
   assign data_o  = data_q;
   assign cfg_o   = cfg_q;
   assign src_o   = src_q;
   assign dst_o   = dst_q;
   assign left_o  = left_q;
   assign param_o = param_q;
   assign state_o = state_q;

endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
   import ldma_pkg::*;
#(
   parameter logic [31:0] END_MARK = 32'hFFFF_F800,
   parameter int          WAIT_W   = 8
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [5:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic [3:0]  mem_be,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        done_o
);

   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("ldma_chan: WAIT_W must lie in 1..8");
   end
   if (END_MARK[1:0] != 2'b00) begin : g_bad_mark
      $error("ldma_chan: END_MARK must be word aligned");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("ldma_chan: data path must be one 32-bit word");
   end

   logic        run_q, pause_q, kick, fin;
   logic [31:0] start_a, st_cfg, st_src, st_dst, st_left, st_param, beat_data;
   logic [2:0]  beat_bytes;
   ldma_state_e seq_state;

   ldma_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .fin_i(fin),
      .st_cfg_i(st_cfg), .st_src_i(st_src), .st_dst_i(st_dst),
      .st_left_i(st_left), .st_param_i(st_param),
      .run_o(run_q), .pause_o(pause_q), .kick_o(kick), .start_o(start_a)
   );

   ldma_seq #(.END_MARK(END_MARK), .WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .run_i(run_q), .pause_i(pause_q), .kick_i(kick), .start_i(start_a),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .beat_bytes_i(beat_bytes),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .data_o(beat_data),
      .cfg_o(st_cfg), .src_o(st_src), .dst_o(st_dst), .left_o(st_left), .param_o(st_param),
      .done_o(done_o), .fin_o(fin), .state_o(seq_state)
   );

   ldma_lane u_lane (
      .src_code_i(st_cfg[10:9]), .dst_code_i(st_cfg[26:25]),
      .src_lane_i(st_src[1:0]),  .dst_lane_i(st_dst[1:0]),
      .data_i(beat_data), .wdata_o(mem_wdata), .be_o(mem_be), .beat_bytes_o(beat_bytes)
   );

endmodule

// File: rtl/ldma_chan_chk.sv
module ldma_chan_chk
   import ldma_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [5:0]  cfg_addr,
   input logic [31:0] cfg_wdata,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [3:0]  mem_be,
   input logic        mem_ack,
   input logic        done_o,
   input ldma_state_e seq_state,
   input logic        pause_q
);

   logic run_write;
   assign run_write = cfg_we && (cfg_addr[5:2] == W_RUN);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !run_write) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R3
   strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !mem_req);

   // R9
   halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_write && !cfg_wdata[0]) |=> !mem_req);

   // R8
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_HOLD && pause_q) |=> !mem_req);

   // R7
   gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_GAP) |-> !mem_req);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_IDLE) |-> (!mem_req && !done_o));

endmodule

bind ldma_chan ldma_chan_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
   .mem_ack(mem_ack), .done_o(done_o), .seq_state(seq_state), .pause_q(pause_q)
);

// File: tb/ldma_chan_tb.sv
module ldma_chan_tb_top;

   localparam logic [31:0] ENDM = 32'hFFFF_F800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req, mem_we, mem_ack, done_o;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   logic [31:0] mem [0:255];
   logic [7:0]  exp_b [0:1023];
   logic        stall_en = 1'b0;
   logic        tick = 1'b0;

   int total = 0, bad = 0, cyc = 0;
   int wr_cnt = 0, req_cnt = 0, done_cnt = 0;
   int low_run = 0, gaps = 0, max_gap = 0, log_n = 0;
   bit seen_req = 0, finished = 0;
   logic [31:0] rd_log [0:5];

   always #10 clk = ~clk;

   assign mem_ack   = !stall_en || tick;
   assign mem_rdata = mem[mem_addr[9:2]];

   ldma_chan dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      tick <= ~tick;
      if (mem_req && mem_ack) begin
         req_cnt <= req_cnt + 1;
         if (!mem_we && log_n < 6) begin
            rd_log[log_n] <= mem_addr;
            log_n <= log_n + 1;
         end
         if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            for (int i = 0; i < 4; i++)
               if (mem_be[i]) mem[mem_addr[9:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
         end
      end
      if (done_o) done_cnt <= done_cnt + 1;
      if (!mem_req) low_run <= low_run + 1;
      else begin
         if (seen_req && low_run > 0) begin
            gaps <= gaps + 1;
            if (low_run > max_gap) max_gap <= low_run;
         end
         low_run  <= 0;
         seen_req <= 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 13 + 7) ^ 8'(a >> 8);
   endfunction

   task automatic fill_mem();
      for (int w = 0; w < 256; w++) begin
         for (int j = 0; j < 4; j++) begin
            mem[w][8*j +: 8] = pat(4*w + j);
            exp_b[4*w + j]   = pat(4*w + j);
         end
      end
   endtask

   function automatic logic [31:0] mk_cfg(input logic [1:0] sw, input logic [1:0] dw,
                                          input logic sfix, input logic dfix, input logic [1:0] bl);
      return {5'd0, dw, 1'b0, bl, dfix, 5'd3, 5'd0, sw, 1'b0, bl, sfix, 5'd7};
   endfunction

   task automatic put_desc(input int base, input logic [31:0] c, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] n, input logic [31:0] p,
                           input logic [31:0] nx);
      mem[base/4 + 0] = c;  mem[base/4 + 1] = s;  mem[base/4 + 2] = d;
      mem[base/4 + 3] = n;  mem[base/4 + 4] = p;  mem[base/4 + 5] = nx;
   endtask

   // byte-level model of one descriptor from the requirements
   task automatic model(input logic [31:0] c, input int s, input int d, input int n);
      int sc, dc, m, bb;
      sc = int'(c[10:9]); dc = int'(c[26:25]);
      m = (sc < dc) ? sc : dc;
      if (m > 2) m = 2;
      bb = 1 << m;
      for (int k = 0; k < n / bb; k++) begin
         int sa, da;
         sa = c[5]  ? s : s + k*bb;
         da = c[21] ? d : d + k*bb;
         for (int j = 0; j < bb; j++) exp_b[da + j] = exp_b[sa + j];
      end
   endtask

   task automatic cfg_write(input logic [5:0] off, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = off; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [5:0] off, output logic [31:0] v);
      @(negedge clk);
      cfg_addr = off;
      #1 v = cfg_rdata;
   endtask

   task automatic clear_mon();
      @(negedge clk);
      wr_cnt = 0; req_cnt = 0; done_cnt = 0; low_run = 0; gaps = 0;
      max_gap = 0; log_n = 0; seen_req = 0;
   endtask

   task automatic start_chain(input logic [31:0] base);
      cfg_write(6'h08, base);
      clear_mon();
      cfg_write(6'h00, 32'd1);
   endtask

   task automatic wait_end(input string req);
      logic [31:0] v;
      int n;
      n = 0;
      do begin
         cfg_read(6'h00, v);
         n++;
      end while (v[0] && n < 5000);
      check(n < 5000, req, n, 5000);
   endtask

   task automatic cmp_dest(input string req);
      int miss;
      miss = 0;
      for (int a = 512; a < 1024; a++)
         if (mem[a/4][8*(a%4) +: 8] !== exp_b[a]) miss++;
      check(miss == 0, req, miss, 0);
   endtask

   typedef struct packed {
      logic [1:0] sw, dw;
      logic       sfix, dfix;
      logic [1:0] bl;
      logic [7:0] cnt, soff, doff, wt;
      logic       stall;
      logic [7:0] beats;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{2'd2, 2'd2, 1'b0, 1'b0, 2'd0, 8'd16, 8'd0, 8'd0,  8'd0, 1'b0, 8'd4},
      '{2'd0, 2'd0, 1'b0, 1'b0, 2'd1, 8'd7,  8'd1, 8'd2,  8'd0, 1'b0, 8'd7},
      '{2'd1, 2'd2, 1'b0, 1'b0, 2'd0, 8'd8,  8'd2, 8'd0,  8'd0, 1'b0, 8'd4},
      '{2'd3, 2'd3, 1'b0, 1'b0, 2'd2, 8'd24, 8'd0, 8'd8,  8'd0, 1'b1, 8'd6},
      '{2'd2, 2'd2, 1'b0, 1'b1, 2'd0, 8'd12, 8'd4, 8'd16, 8'd0, 1'b0, 8'd3},
      '{2'd0, 2'd2, 1'b1, 1'b0, 2'd0, 8'd5,  8'd3, 8'd1,  8'd0, 1'b0, 8'd5},
      '{2'd2, 2'd1, 1'b0, 1'b0, 2'd3, 8'd10, 8'd0, 8'd6,  8'd2, 1'b1, 8'd5}
   };

   initial begin : watchdog
      #(20 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, c, l1;
      int snap_r, snap_w;

      fill_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int w = 0; w < 8; w++) begin
         cfg_read(6'(4*w), v);
         check(v == 0, "R1 register reset value", v, 0);
      end
      check(!mem_req && !done_o, "R1 idle outputs", {mem_req, done_o}, 0);

      // R11 start alignment and read-only words
      cfg_write(6'h08, 32'h0000_0037);
      cfg_read(6'h08, v);
      check(v == 32'h34, "R11 start address aligned", v, 32'h34);
      cfg_write(6'h10, 32'hABCD_0123);
      cfg_write(6'h0C, 32'h5555_AAAA);
      cfg_read(6'h10, v);
      check(v == 0, "R11 source status ignores writes", v, 0);
      cfg_read(6'h0C, v);
      check(v == 0, "R11 config status ignores writes", v, 0);

      // vector table
      for (int t = 0; t < 7; t++) begin
         vec_t e;
         int s, d;
         e = VECS[t];
         fill_mem();
         s = 256 + int'(e.soff);
         d = 512 + int'(e.doff);
         c = mk_cfg(e.sw, e.dw, e.sfix, e.dfix, e.bl);
         put_desc(0, c, s, d, int'(e.cnt), int'(e.wt), ENDM);
         model(c, s, d, int'(e.cnt));
         stall_en = e.stall;
         start_chain(32'h0);
         wait_end("R6 chain end clears run bit");
         stall_en = 1'b0;
         check(wr_cnt == int'(e.beats), "R3 beat count", wr_cnt, e.beats);
         cmp_dest(e.stall ? "R10 data under stalls" : "R3 destination bytes");
         check(done_cnt == 1, "R5 one completion pulse", done_cnt, 1);
         cfg_read(6'h18, v);
         check(v == 0, "R5 bytes left at end", v, 0);
         cfg_read(6'h10, v);
         check(v == (e.sfix ? s : s + int'(e.cnt)), "R4 final source address", v,
               e.sfix ? s : s + int'(e.cnt));
         cfg_read(6'h14, v);
         check(v == (e.dfix ? d : d + int'(e.cnt)), "R4 final destination address", v,
               e.dfix ? d : d + int'(e.cnt));
         cfg_read(6'h0C, v);
         check(v == c, "R2 config readback", v, c);
         cfg_read(6'h1C, v);
         check(v == int'(e.wt), "R2 parameter readback", v, e.wt);
         for (int k = 0; k < 6; k++)
            check(rd_log[k] == 4*k, "R2 descriptor fetch order", rd_log[k], 4*k);
      end

      // R6 two-descriptor chain
      fill_mem();
      c = mk_cfg(2'd2, 2'd2, 1'b0, 1'b0, 2'd0);
      put_desc(0, c, 32'h100, 32'h200, 8, 0, 32'h20);
      model(c, 32'h100, 32'h200, 8);
      c = mk_cfg(2'd0, 2'd0, 1'b0, 1'b0, 2'd0);
      put_desc(32, c, 32'h140, 32'h281, 3, 0, ENDM);
      model(c, 32'h140, 32'h281, 3);
      start_chain(32'h0);
      wait_end("R6 chain end");
      check(done_cnt == 2, "R6 pulses for two descriptors", done_cnt, 2);
      check(wr_cnt == 5, "R6 beats over chain", wr_cnt, 5);
      cmp_dest("R6 chained data");
      cfg_read(6'h14, v);
      check(v == 32'h284, "R6 second descriptor ran", v, 32'h284);

      // R5 zero-length descriptor
      fill_mem();
      put_desc(0, mk_cfg(2'd2, 2'd2, 1'b0, 1'b0, 2'd0), 32'h100, 32'h200, 0, 0, ENDM);
      start_chain(32'h0);
      wait_end("R5 empty descriptor end");
      check(done_cnt == 1, "R5 empty descriptor pulse", done_cnt, 1);
      check(wr_cnt == 0 && req_cnt == 6, "R5 empty descriptor no data access", req_cnt, 6);

      // R7 four-beat bursts with wait 5
      fill_mem();
      put_desc(0, mk_cfg(2'd2, 2'd2, 1'b0, 1'b0, 2'd1), 32'h100, 32'h200, 32, 5, ENDM);
      start_chain(32'h0);
      wait_end("R7 burst run end");
      check(gaps == 1, "R7 gap count with four-beat bursts", gaps, 1);
      check(max_gap == 5, "R7 gap length", max_gap, 5);

      // R7 single-beat bursts with wait 3
      fill_mem();
      put_desc(0, mk_cfg(2'd2, 2'd2, 1'b0, 1'b0, 2'd0), 32'h100, 32'h200, 12, 3, ENDM);
      start_chain(32'h0);
      wait_end("R7 single-beat run end");
      check(gaps == 2, "R7 gap count with single-beat bursts", gaps, 2);
      check(max_gap == 3, "R7 single-beat gap length", max_gap, 3);

      // R8 pause
      fill_mem();
      c = mk_cfg(2'd0, 2'd0, 1'b0, 1'b0, 2'd0);
      put_desc(0, c, 32'h100, 32'h200, 40, 0, ENDM);
      model(c, 32'h100, 32'h200, 40);
      start_chain(32'h0);
      while (wr_cnt < 3) @(negedge clk);
      cfg_write(6'h04, 32'd1);
      repeat (3) @(negedge clk);
      cfg_read(6'h18, l1);
      snap_r = req_cnt;
      repeat (20) @(negedge clk);
      check(req_cnt == snap_r, "R8 no request while paused", req_cnt, snap_r);
      cfg_read(6'h18, v);
      check(v == l1 && l1 != 0, "R8 bytes left held while paused", v, l1);
      cfg_write(6'h04, 32'd0);
      wait_end("R8 resumed run end");
      check(wr_cnt == 40, "R8 all beats after resume", wr_cnt, 40);
      cmp_dest("R8 data after resume");

      // R9 halt
      fill_mem();
      put_desc(0, mk_cfg(2'd0, 2'd0, 1'b0, 1'b0, 2'd0), 32'h100, 32'h200, 64, 0, ENDM);
      start_chain(32'h0);
      while (wr_cnt < 5) @(negedge clk);
      cfg_write(6'h00, 32'd0);
      snap_w = wr_cnt;
      repeat (10) @(negedge clk);
      check(wr_cnt == snap_w && !mem_req, "R9 no writes after halt", wr_cnt, snap_w);
      check(done_cnt == 0, "R9 no pulse after halt", done_cnt, 0);
      cfg_read(6'h00, v);
      check(v == 0, "R9 run bit cleared", v, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule